// File: doc/BRIEF.md
# Atomic-Merge Control Register Window

This block is a bank of byte-wide control registers reached through a 9-bit memory-mapped window. Each access address carries three fields: which register, which operation, and which area. Because the operation sits in the address, one register appears at four aliases: replace, AND-merge, OR-merge and read. Software can therefore set or clear single bits in one bus write, with no read-modify-write sequence and no race against hardware that sets status bits.

The control area holds four kinds of register. A relocation pair gives the shared-RAM base and reports a fixed shared-RAM size. An interrupt-status pair has a global enable bit and flags for timer expiry and illegal accesses. A countdown timer pair and a paging register complete the set. Two identification areas return constant bytes, and one area is reserved. Requests use a valid/ready handshake whose ready is always high. A read returns its byte one cycle after it is accepted.

Top module: `mmio_atomic_window`

## Requirements
- R1: The address is split as idx = addr[4:0] (register), op = addr[6:5] (operation), area = addr[8:7].
- R2: Op 00 writes the byte and op 11 reads. req_ready is always 1. A read accepted at a clock edge drives rsp_valid=1 with the data on rsp_rdata after that edge, for one cycle. Unimplemented control registers read 0x00.
- R3: Op 01 stores register AND write byte in a single cycle, and the next read shows the result.
- R4: Op 10 stores register OR write byte in a single cycle, and the next read shows the result.
- R5: Register 0 (relocation, even) keeps bits 7:1 and reads bit 0 as 0. ram_base drives its bits 7:1, which are shared-RAM address bits 19:13.
- R6: Register 1 (relocation, odd) reads RAM_SIZE_CODE in bits 3:2 and 0 elsewhere (00=8 KB, 01=16 KB, 10=32 KB, 11=64 KB; the default is 10, so it reads 0x08). Writes to it change nothing and count as illegal.
- R7: The implemented writable control registers are 0, 8, 9, 12, 14 and 24. A write to any other control register, or to any area other than 00, sets bit 2 of register 8 and changes no register.
- R8: A read in area 01 returns 0x00 and sets bit 2 of register 8.
- R9: Area 10 returns ID_SEED XOR idx (default seed 0xA0). Area 11 returns 0x55 at even idx and 0xAA at odd idx.
- R10: When bit 7 of register 12 is 1, register 14 decrements once per cycle while it is nonzero. The decrement from 1 to 0 sets bit 4 of register 8. When bit 7 is 0, register 14 holds. Register 12 keeps only bit 7.
- R11: Register 8 keeps bits 6, 4 and 2, and register 9 keeps bits 6:2. irq is a register loaded with reg8[6] AND (reg8[4] OR reg8[2] OR any reg9 bit). With bit 6 at 0, irq is 0.
- R12: paging_en is 1 exactly when register 24 holds 0xC0.
- R13: After reset, all registers are 0 and irq, rsp_valid, paging_en and ram_base are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Request accepted (always 1) |
| req_addr | input | 9 | Area, operation and register fields |
| req_wdata | input | 8 | Write or merge byte |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 8 | Read data |
| irq | output | 1 | Registered interrupt request |
| ram_base | output | 7 | Shared-RAM base, address bits 19:13 |
| paging_en | output | 1 | Paging enabled |

## Verification
The bench checks that AND and OR merges act on the stored value. A design that swapped the two opcodes, or that replaced the register instead of merging, would read back the wrong byte. It writes to the read-only size register, to a hole in the map, and to an identification area. A design that decoded only the register field would corrupt state or fail to raise the access flag. It times the countdown across the 1-to-0 step and toggles the enable with status pending. An off-by-one expiry, or an ungated interrupt, would show up on the status read or on irq.

// File: rtl/mmio_win_pkg.sv
// Package: shared encodings and slot tables for the register window.
// Assumes byte-wide registers and a 5-bit register field.
package mmio_win_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b00,
        OP_AND   = 2'b01,
        OP_OR    = 2'b10,
        OP_READ  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        AR_CTRL = 2'b00,
        AR_RSVD = 2'b01,
        AR_ID   = 2'b10,
        AR_PAT  = 2'b11
    } area_e;

    localparam int unsigned IDX_W     = 5;
    localparam int unsigned NUM_PLAIN = 4;

    // Plain storage slots: relocation even, status odd, timer control, paging.
    localparam logic [IDX_W-1:0] PLAIN_IDX  [NUM_PLAIN] = '{5'd0, 5'd9, 5'd12, 5'd24};
    localparam logic [7:0]       PLAIN_MASK [NUM_PLAIN] = '{8'hFE, 8'h7C, 8'h80, 8'hFF};

    localparam int unsigned SLOT_RELOC = 0;
    localparam int unsigned SLOT_HSTO  = 1;
    localparam int unsigned SLOT_TCTL  = 2;
    localparam int unsigned SLOT_PAGE  = 3;

    localparam logic [IDX_W-1:0] IX_RELOC_O = 5'd1;
    localparam logic [IDX_W-1:0] IX_HST_E   = 5'd8;
    localparam logic [IDX_W-1:0] IX_TVAL    = 5'd14;

    localparam logic [7:0] HST_E_MASK = 8'h54;
    localparam logic [7:0] PAGING_KEY = 8'hC0;

    // Apply the operation encoded in the address to a stored byte.
    function automatic logic [7:0] merge_byte(op_e op, logic [7:0] q, logic [7:0] d);
        case (op)
            OP_AND:  merge_byte = q & d;
            OP_OR:   merge_byte = q | d;
            default: merge_byte = d;
        endcase
    endfunction

endpackage

// File: rtl/mmio_addr_decode.sv
// Address decoder: splits the window address into register, operation and
// area fields and produces per-register hit lines for the control area.
// Assumes a 9-bit address; pure combinational.
module mmio_addr_decode
    import mmio_win_pkg::*;
(
    input  logic [8:0]           addr,
    output logic [IDX_W-1:0]     idx,
    output op_e                  op,
    output area_e                area,
    output logic [NUM_PLAIN-1:0] plain_hit,
    output logic                 hit_hst_e,
    output logic                 hit_tval,
    output logic                 hit_reloc_o
);

    assign idx  = addr[IDX_W-1:0];
    assign op   = op_e'(addr[6:5]);
    assign area = area_e'(addr[8:7]);

    // One comparator per plain storage slot.
    for (genvar s = 0; s < NUM_PLAIN; s++) begin : g_hit
        assign plain_hit[s] = (area == AR_CTRL) && (idx == PLAIN_IDX[s]);
    end

    assign hit_hst_e   = (area == AR_CTRL) && (idx == IX_HST_E);
    assign hit_tval    = (area == AR_CTRL) && (idx == IX_TVAL);
    assign hit_reloc_o = (area == AR_CTRL) && (idx == IX_RELOC_O);

endmodule

// File: rtl/mmio_countdown.sv
// Countdown timer: loadable down-counter that stops at zero.
// Assumes a load takes priority over a decrement in the same cycle.
module mmio_countdown #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] val,
    output logic         expire
);

    // Load, decrement while running and nonzero, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                  val <= '0;
        else if (load)               val <= load_val;
        else if (run && val != '0)   val <= val - 1'b1;
    end

    // Expiry marks the cycle in which the count steps from one to zero.
    assign expire = run && !load && (val == W'(1));

    p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && val != '0) |=> (val == $past(val) - 1'b1));

    p_count_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(val));

endmodule

// File: rtl/mmio_id_bytes.sv
// Identification areas: constant bytes computed from the register index.
// Assumes area 10 holds a seeded address code and area 11 a test pattern.
module mmio_id_bytes
    import mmio_win_pkg::*;
#(
    parameter logic [7:0] ID_SEED = 8'hA0
) (
    input  area_e            area,
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       byte_out
);

    // Select the constant byte for the addressed identification slot.
    always_comb begin
        case (area)
            AR_ID:   byte_out = ID_SEED ^ {{(8-IDX_W){1'b0}}, idx};
            AR_PAT:  byte_out = idx[0] ? 8'hAA : 8'h55;
            default: byte_out = 8'h00;
        endcase
    end

endmodule

// File: rtl/mmio_atomic_window.sv
// Top: byte register window with write / AND / OR / read aliases per register.
// Holds relocation, interrupt-status, timer and paging registers, flags
// illegal accesses and returns read data one cycle after acceptance.
// Assumes req_ready is permanently high and one access per cycle.
module mmio_atomic_window
    import mmio_win_pkg::*;
#(
    parameter logic [1:0] RAM_SIZE_CODE = 2'b10,
    parameter logic [7:0] ID_SEED       = 8'hA0,
    parameter int unsigned DATA_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [8:0]        req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              irq,
    output logic [6:0]        ram_base,
    output logic              paging_en
);

    localparam logic [7:0] RELOC_O_VAL = {4'b0, RAM_SIZE_CODE, 2'b0};

    logic [IDX_W-1:0]     idx;
    op_e                  op;
    area_e                area;
    logic [NUM_PLAIN-1:0] plain_hit;
    logic                 hit_hst_e, hit_tval, hit_reloc_o;
    logic                 acc, wr_acc, rd_acc, legal_wr, bad_wr, bad_rd;
    logic [7:0]           slot_q [NUM_PLAIN];
    logic [7:0]           hst_e_q, hst_e_base;
    logic [7:0]           tval, id_byte, rd_mux;
    logic                 expire;

    assign req_ready = 1'b1;

    mmio_addr_decode u_dec (
        .addr        (req_addr),
        .idx         (idx),
        .op          (op),
        .area        (area),
        .plain_hit   (plain_hit),
        .hit_hst_e   (hit_hst_e),
        .hit_tval    (hit_tval),
        .hit_reloc_o (hit_reloc_o)
    );

    assign acc      = req_valid && req_ready;
    assign wr_acc   = acc && (op != OP_READ);
    assign rd_acc   = acc && (op == OP_READ);
    assign legal_wr = (|plain_hit) || hit_hst_e || hit_tval;
    assign bad_wr   = wr_acc && !legal_wr;
    assign bad_rd   = rd_acc && (area == AR_RSVD);

    // Plain slots: masked merge of the addressed register.
    always_ff @(posedge clk) begin
        for (int s = 0; s < NUM_PLAIN; s++) begin
            if (!rst_n)
                slot_q[s] <= 8'h00;
            else if (wr_acc && plain_hit[s])
                slot_q[s] <= merge_byte(op, slot_q[s], req_wdata) & PLAIN_MASK[s];
        end
    end

    mmio_countdown #(.W(8)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (slot_q[SLOT_TCTL][7]),
        .load     (wr_acc && hit_tval),
        .load_val (merge_byte(op, tval, req_wdata)),
        .val      (tval),
        .expire   (expire)
    );

    // Software update of the even status register before hardware events.
    always_comb begin
        hst_e_base = hst_e_q;
        if (wr_acc && hit_hst_e)
            hst_e_base = merge_byte(op, hst_e_q, req_wdata) & HST_E_MASK;
    end

    // Even status register: hardware events win over software clears.
    always_ff @(posedge clk) begin
        if (!rst_n) hst_e_q <= 8'h00;
        else        hst_e_q <= hst_e_base | {3'b0, expire, 1'b0, bad_wr || bad_rd, 2'b0};
    end

    mmio_id_bytes #(.ID_SEED(ID_SEED)) u_id (
        .area     (area),
        .idx      (idx),
        .byte_out (id_byte)
    );

    // Read data selection across areas and control registers.
    always_comb begin
        rd_mux = 8'h00;
        if (area == AR_CTRL) begin
            for (int s = 0; s < NUM_PLAIN; s++)
                if (plain_hit[s]) rd_mux = slot_q[s];
            if (hit_hst_e)   rd_mux = hst_e_q;
            if (hit_tval)    rd_mux = tval;
            if (hit_reloc_o) rd_mux = RELOC_O_VAL;
        end else begin
            rd_mux = id_byte;
        end
    end

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_acc;
            rsp_rdata <= rd_acc ? rd_mux : '0;
        end
    end

    // Registered interrupt: enabled OR of pending status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= hst_e_q[6] && (hst_e_q[4] || hst_e_q[2] || (|slot_q[SLOT_HSTO]));
    end

    assign ram_base  = slot_q[SLOT_RELOC][7:1];
    assign paging_en = (slot_q[SLOT_PAGE] == PAGING_KEY);

    p_irq_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !hst_e_q[6] |=> !irq);

    p_read_response_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> rsp_valid);

    p_no_response_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> !rsp_valid);

    p_illegal_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr |=> hst_e_q[2]);

    p_reserved_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bad_rd |=> hst_e_q[2]);

    p_and_merge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && op == OP_AND && plain_hit[SLOT_PAGE])
        |=> slot_q[SLOT_PAGE] == ($past(slot_q[SLOT_PAGE]) & $past(req_wdata)));

    p_or_merge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && op == OP_OR && plain_hit[SLOT_PAGE])
        |=> slot_q[SLOT_PAGE] == ($past(slot_q[SLOT_PAGE]) | $past(req_wdata)));

endmodule

// File: tb/tb_mmio_atomic_window.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_mmio_atomic_window;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [8:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       rsp_valid;
    logic [7:0] rsp_rdata;
    logic       irq;
    logic [6:0] ram_base;
    logic       paging_en;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    mmio_atomic_window dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .irq(irq), .ram_base(ram_base), .paging_en(paging_en)
    );

    localparam logic [1:0] A_CTRL = 2'b00, A_RSVD = 2'b01, A_ID = 2'b10, A_PAT = 2'b11;
    localparam logic [1:0] O_WR = 2'b00, O_AND = 2'b01, O_OR = 2'b10, O_RD = 2'b11;

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic acc(input logic [1:0] area, input logic [1:0] op,
                       input logic [4:0] idx, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = {area, op, idx};
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        req_wdata = '0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] area,
                          input logic [4:0] idx, input logic [7:0] exp);
        acc(area, O_RD, idx, 8'h00);
        check({tag, " rsp_valid"}, {7'b0, rsp_valid}, 8'h01);
        check(tag, rsp_rdata, exp);
    endtask

    task automatic t_reset;
        check("R13 irq", {7'b0, irq}, 8'h00);
        check("R13 paging_en", {7'b0, paging_en}, 8'h00);
        check("R13 ram_base", {1'b0, ram_base}, 8'h00);
        check("R13 rsp_valid", {7'b0, rsp_valid}, 8'h00);
        check("R2 req_ready", {7'b0, req_ready}, 8'h01);
        rd_chk("R13 status even", A_CTRL, 5'd8, 8'h00);
        rd_chk("R6 size code", A_CTRL, 5'd1, 8'h08);
    endtask

    task automatic t_write_read;
        acc(A_CTRL, O_WR, 5'd24, 8'h3C);
        rd_chk("R2 R1 page readback", A_CTRL, 5'd24, 8'h3C);
        acc(A_CTRL, O_WR, 5'd12, 8'hFF);
        rd_chk("R10 timer ctrl mask", A_CTRL, 5'd12, 8'h80);
        acc(A_CTRL, O_WR, 5'd12, 8'h00);
        rd_chk("R2 unimplemented reads zero", A_CTRL, 5'd20, 8'h00);
    endtask

    task automatic t_merge;
        acc(A_CTRL, O_WR, 5'd24, 8'hF0);
        acc(A_CTRL, O_OR, 5'd24, 8'h0F);
        rd_chk("R4 or merge", A_CTRL, 5'd24, 8'hFF);
        acc(A_CTRL, O_AND, 5'd24, 8'h3C);
        rd_chk("R3 and merge", A_CTRL, 5'd24, 8'h3C);
        acc(A_CTRL, O_WR, 5'd24, 8'hC0);
        check("R12 paging on", {7'b0, paging_en}, 8'h01);
        acc(A_CTRL, O_OR, 5'd24, 8'h01);
        check("R12 paging off", {7'b0, paging_en}, 8'h00);
    endtask

    task automatic t_reloc;
        acc(A_CTRL, O_WR, 5'd0, 8'hFF);
        rd_chk("R5 bit0 reads zero", A_CTRL, 5'd0, 8'hFE);
        check("R5 base all ones", {1'b0, ram_base}, 8'h7F);
        acc(A_CTRL, O_AND, 5'd0, 8'h81);
        check("R5 base after and", {1'b0, ram_base}, 8'h40);
    endtask

    task automatic t_illegal;
        acc(A_CTRL, O_WR, 5'd8, 8'h00);
        acc(A_CTRL, O_WR, 5'd3, 8'h55);
        rd_chk("R7 hole write flags", A_CTRL, 5'd8, 8'h04);
        rd_chk("R7 hole still zero", A_CTRL, 5'd3, 8'h00);
        acc(A_CTRL, O_WR, 5'd8, 8'h00);
        acc(A_CTRL, O_OR, 5'd1, 8'hF3);
        rd_chk("R6 ro write flags", A_CTRL, 5'd8, 8'h04);
        rd_chk("R6 size unchanged", A_CTRL, 5'd1, 8'h08);
        acc(A_CTRL, O_WR, 5'd8, 8'h00);
        acc(A_ID, O_WR, 5'd24, 8'h11);
        rd_chk("R7 id-area write flags", A_CTRL, 5'd8, 8'h04);
        rd_chk("R7 page not aliased", A_CTRL, 5'd24, 8'hC1);
        acc(A_CTRL, O_WR, 5'd8, 8'h00);
        rd_chk("R7 flag cleared", A_CTRL, 5'd8, 8'h00);
    endtask

    task automatic t_reserved;
        rd_chk("R8 reserved reads zero", A_RSVD, 5'd2, 8'h00);
        rd_chk("R8 reserved read flags", A_CTRL, 5'd8, 8'h04);
        acc(A_CTRL, O_AND, 5'd8, 8'h00);
    endtask

    task automatic t_id;
        rd_chk("R9 id idx5", A_ID, 5'd5, 8'hA0 ^ 8'h05);
        rd_chk("R9 id idx31", A_ID, 5'd31, 8'hA0 ^ 8'h1F);
        rd_chk("R9 pattern odd", A_PAT, 5'd3, 8'hAA);
        rd_chk("R9 pattern even", A_PAT, 5'd4, 8'h55);
    endtask

    task automatic t_timer;
        acc(A_CTRL, O_WR, 5'd14, 8'h05);
        repeat (4) @(negedge clk);
        rd_chk("R10 hold when stopped", A_CTRL, 5'd14, 8'h05);
        acc(A_CTRL, O_WR, 5'd12, 8'h80);
        acc(A_CTRL, O_WR, 5'd14, 8'h03);
        rd_chk("R10 no early expiry", A_CTRL, 5'd8, 8'h00);
        repeat (5) @(negedge clk);
        rd_chk("R10 expiry flag", A_CTRL, 5'd8, 8'h10);
        rd_chk("R10 stops at zero", A_CTRL, 5'd14, 8'h00);
        acc(A_CTRL, O_WR, 5'd12, 8'h00);
        acc(A_CTRL, O_AND, 5'd8, 8'hEF);
        rd_chk("R10 flag cleared", A_CTRL, 5'd8, 8'h00);
    endtask

    task automatic t_irq;
        acc(A_CTRL, O_WR, 5'd9, 8'h20);
        repeat (2) @(negedge clk);
        check("R11 disabled irq low", {7'b0, irq}, 8'h00);
        acc(A_CTRL, O_OR, 5'd8, 8'h40);
        @(negedge clk);
        check("R11 odd status irq", {7'b0, irq}, 8'h01);
        acc(A_CTRL, O_AND, 5'd9, 8'h00);
        @(negedge clk);
        check("R11 irq drops", {7'b0, irq}, 8'h00);
        acc(A_CTRL, O_WR, 5'd7, 8'h01);
        @(negedge clk);
        check("R11 access irq", {7'b0, irq}, 8'h01);
        acc(A_CTRL, O_AND, 5'd8, 8'h04);
        @(negedge clk);
        check("R11 gated by enable", {7'b0, irq}, 8'h00);
        rd_chk("R11 pending kept", A_CTRL, 5'd8, 8'h04);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_write_read;
        t_merge;
        t_reloc;
        t_illegal;
        t_reserved;
        t_id;
        t_timer;
        t_irq;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired got 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule